// File: doc/BRIEF.md
# Programmable Display Sync Timing Generator

This block produces the line and frame timing for a parallel RGB panel. A pixel counter and a line counter advance on a pixel clock enable. Horizontal sync, vertical sync and data-enable are decoded from the counters. The decode uses programmable boundaries that are given as running sums: the sync width, then sync plus back porch, then that plus the active area, and finally the full line or frame length. Each output pin has its own polarity bit.

Software reads the current pixel position and a live status word, which always show the signals active-high. Software can also name one line. When the scan reaches the first pixel clock of that line, a sticky flag is set, and an interrupt is raised if it is enabled. A plain write strobe with an address index loads every setting.

Top module: `disp_timing_gen`

## Requirements
- R1: When enabled, on each pixel-enable cycle the pixel count goes up by one. When the pixel count is at or above the programmed line total, it returns to 0 and the line count goes up by one. The line count returns to 0 when it is at or above the frame total. Both counts appear on `pos_o` one cycle after the edge, with the pixel count in bits 31:16 and the line count in bits 15:0.
- R2: Horizontal sync is active while the pixel count is below the horizontal sync width. Vertical sync is active while the line count is below the vertical sync width.
- R3: Horizontal data-enable is active when the pixel count is at least the back-porch sum and below the active sum. Vertical data-enable follows the same rule using the line count. The pin data-enable is the AND of the two.
- R4: Control bit 31 sets the polarity of the hsync pin, bit 30 the vsync pin, bit 29 the data-enable pin and bit 28 the pixel clock. A value of 1 drives the pin high when active; a value of 0 drives it low when active. The pixel clock bit is passed to `pclk_pol_o`. Polarity never changes `status_o`.
- R5: Control bit 0 enables the block. While it is 0, and after reset (when every register is zero), both counts stay at 0, `status_o` is 0, and every pin sits at its inactive level.
- R6: While `pix_ce` is low, both counts hold their values.
- R7: The line-mark flag (`lm_flag_o`) is set one cycle after a pixel-enable cycle in which the pixel count is 0 and the line count equals the 11-bit line-mark value. This happens once per frame.
- R8: Writing a value with bit 0 set to the clear address clears the flag. If a clear and a set fall in the same cycle, the set wins.
- R9: `irq_o` is high exactly when the flag is set and the interrupt enable bit is 1.
- R10: The write address indexes are: 0 sync widths, 1 back-porch sums, 2 active sums, 3 totals, 4 control, 5 line mark (bits 10:0), 6 interrupt enable (bit 0), 7 flag clear. In registers 0 to 3, the horizontal value is in bits 27:16 and the vertical value is in bits 11:0. A write takes effect on the next cycle.
- R11: In `status_o`, bit 0 is vertical data-enable, bit 1 is horizontal data-enable, bit 2 is vsync and bit 3 is hsync, all shown active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| pclk_pol_o | output | 1 | Pixel clock polarity select |
| pos_o | output | 32 | Pixel count (31:16) and line count (15:0) |
| status_o | output | 4 | Live sync and data-enable status |
| lm_flag_o | output | 1 | Line-mark flag |
| irq_o | output | 1 | Line-mark interrupt |

## Verification
The assertions check the following on every cycle:
- The counters are cleared while the block is disabled.
- The counts freeze when no pixel enable is present.
- The pixel count steps by exactly one below the total.
- A set of the flag takes priority over a clear.
- A clear alone takes effect.

Other behaviour needs the bench's scenarios and its behavioural model:
- The wrap points.
- The sync and data-enable windows for several boundary sets, including empty windows.
- Polarity applied to the pins only.
- The line mark firing once per frame under a sparse pixel enable.
- The masking of the interrupt.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
    localparam int TW = 12;
    localparam int LW = 11;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_SYNC  = 3'd0;
    localparam logic [AW-1:0] A_BPSUM = 3'd1;
    localparam logic [AW-1:0] A_ACTS  = 3'd2;
    localparam logic [AW-1:0] A_TOTAL = 3'd3;
    localparam logic [AW-1:0] A_CTRL  = 3'd4;
    localparam logic [AW-1:0] A_LMARK = 3'd5;
    localparam logic [AW-1:0] A_IEN   = 3'd6;
    localparam logic [AW-1:0] A_FCLR  = 3'd7;

    localparam int HLO = 16;
    localparam int VLO = 0;

    typedef struct packed {
        logic [TW-1:0] hsw;
        logic [TW-1:0] hbp;
        logic [TW-1:0] hact;
        logic [TW-1:0] htot;
        logic [TW-1:0] vsw;
        logic [TW-1:0] vbp;
        logic [TW-1:0] vact;
        logic [TW-1:0] vtot;
        logic [LW-1:0] lmark;
        logic          en;
        logic          hpol;
        logic          vpol;
        logic          dpol;
        logic          cpol;
        logic          lm_ie;
    } tcfg_t;
endpackage

// File: rtl/timing_cfg_regs.sv
module timing_cfg_regs
    import disp_timing_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [31:0]   wdata_i,
    output tcfg_t         cfg_o,
    output logic          clr_o
);
    tcfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        clr_o = 1'b0;
        if (wr_i) begin
            unique case (addr_i)
                A_SYNC: begin
                    cfg_d.hsw = wdata_i[HLO +: TW];
                    cfg_d.vsw = wdata_i[VLO +: TW];
                end
                A_BPSUM: begin
                    cfg_d.hbp = wdata_i[HLO +: TW];
                    cfg_d.vbp = wdata_i[VLO +: TW];
                end
                A_ACTS: begin
                    cfg_d.hact = wdata_i[HLO +: TW];
                    cfg_d.vact = wdata_i[VLO +: TW];
                end
                A_TOTAL: begin
                    cfg_d.htot = wdata_i[HLO +: TW];
                    cfg_d.vtot = wdata_i[VLO +: TW];
                end
                A_CTRL: begin
                    cfg_d.en   = wdata_i[0];
                    cfg_d.cpol = wdata_i[28];
                    cfg_d.dpol = wdata_i[29];
                    cfg_d.vpol = wdata_i[30];
                    cfg_d.hpol = wdata_i[31];
                end
                A_LMARK: cfg_d.lmark = wdata_i[LW-1:0];
                A_IEN:   cfg_d.lm_ie = wdata_i[0];
                A_FCLR:  clr_o       = wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/timing_counters.sv
module timing_counters #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         ce_i,
    input  logic [W-1:0] htot_i,
    input  logic [W-1:0] vtot_i,
    output logic [W-1:0] hcnt_o,
    output logic [W-1:0] vcnt_o,
    output logic         line_start_o
);
    typedef struct packed {
        logic [W-1:0] h;
        logic [W-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i) begin
            cnt_d = '0;
        end else if (ce_i) begin
            if (cnt_q.h >= htot_i) begin
                cnt_d.h = '0;
                cnt_d.v = (cnt_q.v >= vtot_i) ? '0 : cnt_q.v + 1'b1;
            end else begin
                cnt_d.h = cnt_q.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hcnt_o       = cnt_q.h;
    assign vcnt_o       = cnt_q.v;
    assign line_start_o = en_i && ce_i && (cnt_q.h == '0);

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (hcnt_o == '0 && vcnt_o == '0)); // R5
    AST_NO_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ce_i) |=> ($stable(hcnt_o) && $stable(vcnt_o))); // R6
    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ce_i && hcnt_o < htot_i) |=> (hcnt_o == $past(hcnt_o) + 1'b1)); // R1
endmodule

// File: rtl/sync_decode.sv
module sync_decode
    import disp_timing_pkg::*;
(
    input  tcfg_t         cfg_i,
    input  logic [TW-1:0] hcnt_i,
    input  logic [TW-1:0] vcnt_i,
    output logic [3:0]    status_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o
);
    logic hs, vs, hde, vde;

    always_comb begin
        hs  = cfg_i.en && (hcnt_i < cfg_i.hsw);
        vs  = cfg_i.en && (vcnt_i < cfg_i.vsw);
        hde = cfg_i.en && (hcnt_i >= cfg_i.hbp) && (hcnt_i < cfg_i.hact);
        vde = cfg_i.en && (vcnt_i >= cfg_i.vbp) && (vcnt_i < cfg_i.vact);
        status_o = {hs, vs, hde, vde};
        hsync_o  = cfg_i.hpol ? hs : ~hs;
        vsync_o  = cfg_i.vpol ? vs : ~vs;
        de_o     = cfg_i.dpol ? (hde & vde) : ~(hde & vde);
    end
endmodule

// File: rtl/line_mark_irq.sv
module line_mark_irq #(
    parameter int W  = 12,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start_i,
    input  logic [W-1:0]  vcnt_i,
    input  logic [LW-1:0] lmark_i,
    input  logic          clr_i,
    input  logic          ie_i,
    output logic          flag_o,
    output logic          irq_o
);
    logic match;
    logic flag_d, flag_q;

    always_comb begin
        match  = line_start_i && (vcnt_i == W'(lmark_i));
        flag_d = flag_q;
        if (match)      flag_d = 1'b1;
        else if (clr_i) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & ie_i;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_o); // R8
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !match) |=> !flag_o); // R8
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import disp_timing_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_ce,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          pclk_pol_o,
    output logic [31:0]   pos_o,
    output logic [3:0]    status_o,
    output logic          lm_flag_o,
    output logic          irq_o
);
    localparam int PW = 16;

    tcfg_t         cfg;
    logic          clr;
    logic [TW-1:0] hcnt, vcnt;
    logic          line_start;

    timing_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .cfg_o   (cfg),
        .clr_o   (clr)
    );

    timing_counters #(.W(TW)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (cfg.en),
        .ce_i         (pix_ce),
        .htot_i       (cfg.htot),
        .vtot_i       (cfg.vtot),
        .hcnt_o       (hcnt),
        .vcnt_o       (vcnt),
        .line_start_o (line_start)
    );

    sync_decode u_dec (
        .cfg_i    (cfg),
        .hcnt_i   (hcnt),
        .vcnt_i   (vcnt),
        .status_o (status_o),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .de_o     (de_o)
    );

    line_mark_irq #(.W(TW), .LW(LW)) u_lm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start),
        .vcnt_i       (vcnt),
        .lmark_i      (cfg.lmark),
        .clr_i        (clr),
        .ie_i         (cfg.lm_ie),
        .flag_o       (lm_flag_o),
        .irq_o        (irq_o)
    );

    assign pclk_pol_o = cfg.cpol;
    assign pos_o      = {PW'(hcnt), PW'(vcnt)};

    AST_OFF_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[0]) |=> (status_o == 4'd0)); // R5
endmodule

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        hsync_o, vsync_o, de_o, pclk_pol_o, lm_flag_o, irq_o;
    logic [31:0] pos_o;
    logic [3:0]  status_o;

    always #4 clk = ~clk;

    disp_timing_gen i_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .pclk_pol_o(pclk_pol_o),
        .pos_o(pos_o), .status_o(status_o), .lm_flag_o(lm_flag_o), .irq_o(irq_o)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_h, m_v, m_hsw, m_hbp, m_hact, m_htot, m_vsw, m_vbp, m_vact, m_vtot, m_lm;
    bit m_en, m_hp, m_vp, m_dp, m_cp, m_ie, m_flag;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        int nh, nv;
        bit match, clr;
        if (!rst_n) begin
            m_h = 0; m_v = 0; m_hsw = 0; m_hbp = 0; m_hact = 0; m_htot = 0;
            m_vsw = 0; m_vbp = 0; m_vact = 0; m_vtot = 0; m_lm = 0;
            m_en = 0; m_hp = 0; m_vp = 0; m_dp = 0; m_cp = 0; m_ie = 0; m_flag = 0;
        end else begin
            match = m_en && pix_ce && m_h == 0 && m_v == m_lm;
            clr   = reg_wr && reg_addr == 3'd7 && reg_wdata[0];
            nh = m_h; nv = m_v;
            if (!m_en) begin
                nh = 0; nv = 0;
            end else if (pix_ce) begin
                if (m_h >= m_htot) begin
                    nh = 0;
                    nv = (m_v >= m_vtot) ? 0 : m_v + 1;
                end else nh = m_h + 1;
            end
            m_h = nh; m_v = nv;
            if (match) m_flag = 1;
            else if (clr) m_flag = 0;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin m_hsw  = int'(reg_wdata[27:16]); m_vsw  = int'(reg_wdata[11:0]); end
                    3'd1: begin m_hbp  = int'(reg_wdata[27:16]); m_vbp  = int'(reg_wdata[11:0]); end
                    3'd2: begin m_hact = int'(reg_wdata[27:16]); m_vact = int'(reg_wdata[11:0]); end
                    3'd3: begin m_htot = int'(reg_wdata[27:16]); m_vtot = int'(reg_wdata[11:0]); end
                    3'd4: begin
                        m_en = reg_wdata[0]; m_cp = reg_wdata[28]; m_dp = reg_wdata[29];
                        m_vp = reg_wdata[30]; m_hp = reg_wdata[31];
                    end
                    3'd5: m_lm = int'(reg_wdata[10:0]);
                    3'd6: m_ie = reg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit hs, vs, hde, vde, de;
        if (rst_n && !done) begin
            hs  = m_en && m_h < m_hsw;
            vs  = m_en && m_v < m_vsw;
            hde = m_en && m_h >= m_hbp && m_h < m_hact;
            vde = m_en && m_v >= m_vbp && m_v < m_vact;
            de  = hde && vde;
            chk("R1 position", pos_o, (m_h << 16) | m_v);
            chk("R11 status", {28'd0, status_o}, {28'd0, hs, vs, hde, vde});
            chk("R2 R4 hsync pin", {31'd0, hsync_o}, {31'd0, m_hp ? hs : !hs});
            chk("R2 R4 vsync pin", {31'd0, vsync_o}, {31'd0, m_vp ? vs : !vs});
            chk("R3 R4 de pin", {31'd0, de_o}, {31'd0, m_dp ? de : !de});
            chk("R4 pclk polarity", {31'd0, pclk_pol_o}, {31'd0, m_cp});
            chk("R7 line mark flag", {31'd0, lm_flag_o}, {31'd0, m_flag});
            chk("R9 irq", {31'd0, irq_o}, {31'd0, m_flag && m_ie});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state (R5)
        chk("R5 reset pos", pos_o, 32'd0);
        chk("R5 reset status", {28'd0, status_o}, 32'd0);
        chk("R5 reset pins", {29'd0, hsync_o, vsync_o, de_o}, 32'd7);
        chk("R5 reset flag irq", {30'd0, lm_flag_o, irq_o}, 32'd0);
        rst_n = 1'b1;

        // R10 program timing: small panel
        wr(3'd0, (32'd2 << 16) | 32'd1);
        wr(3'd1, (32'd4 << 16) | 32'd2);
        wr(3'd2, (32'd12 << 16) | 32'd6);
        wr(3'd3, (32'd15 << 16) | 32'd8);
        wr(3'd5, 32'd3);
        wr(3'd6, 32'd1);
        run(4);
        chk("R5 still disabled", pos_o, 32'd0);
        wr(3'd4, 32'hA000_0001);
        run(300);

        // R6 sparse pixel enable
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            pix_ce = (i % 3 == 0);
        end
        @(negedge clk);
        pix_ce = 1'b0;
        run(5);
        chk("R6 frozen count", pos_o, (m_h << 16) | m_v);
        pix_ce = 1'b1;

        // R4 other polarity combination
        wr(3'd4, 32'h5000_0001);
        run(200);

        // R8 plain clear
        wr(3'd7, 32'd1);
        chk("R8 cleared", {31'd0, lm_flag_o}, {31'd0, m_flag});

        // R8 set wins over clear in the same cycle
        do @(negedge clk); while (!(m_h == 0 && m_v == 3));
        reg_wr = 1'b1; reg_addr = 3'd7; reg_wdata = 32'd1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 set wins", {31'd0, lm_flag_o}, 32'd1);

        // R9 masked interrupt, R7 line mark at line 0
        wr(3'd6, 32'd0);
        chk("R9 masked", {31'd0, irq_o}, 32'd0);
        wr(3'd5, 32'd0);
        wr(3'd7, 32'd1);
        run(300);
        wr(3'd6, 32'd1);
        run(50);

        // R5 disable mid-frame
        run(37);
        wr(3'd4, 32'h0000_0000);
        run(3);
        chk("R5 disabled pos", pos_o, 32'd0);
        chk("R5 disabled pins", {29'd0, hsync_o, vsync_o, de_o}, 32'd7);
        wr(3'd4, 32'hF000_0001);
        run(100);

        // R2 R3 edge windows: back porch equal to sync, empty active area
        wr(3'd0, (32'd3 << 16) | 32'd2);
        wr(3'd1, (32'd3 << 16) | 32'd2);
        wr(3'd2, (32'd3 << 16) | 32'd5);
        wr(3'd3, (32'd9 << 16) | 32'd6);
        run(250);
        wr(3'd2, (32'd8 << 16) | 32'd5);
        run(250);
        // R1 shrink total below current count forces wrap
        wr(3'd3, (32'd2 << 16) | 32'd1);
        run(40);

        finish_run();
    end
endmodule